// File: doc/BRIEF.md
# Field-synchronous plane descriptor chain fetcher

This block keeps a display plane's working configuration up to date by walking a chain of descriptors held in memory. Each descriptor is sixteen 32-bit words: control, alpha gain, viewport corners, pixel base and pitch, source size, colour keys, a properties word, a colour-map pointer, and a link to the descriptor that should follow it. On every field or frame sync pulse the block reads the descriptor at its current fetch pointer, one word per memory transfer. Once all sixteen words are in, it swaps them into the output registers in one step and adopts the descriptor's link as the next fetch pointer.

The usual setup is two descriptors linked to each other, one for each field, so the plane alternates between them with no software action. Software steers the chain by writing the pointer register. The value it writes is shown at once on the pointer read-back, and the block uses it at the next sync. A descriptor can ask to be held back until the sync after its fetch. If a fetch overruns into the next sync, the old configuration stays in place and a sticky late flag is raised.

Top module: `node_chain_fetcher`

## Requirements
- R1: After reset, `ptr_o`, `node_o`, `plane_on_o`, `late_o` and `mem_req_o` are all zero.
- R2: At a sync with a non-zero fetch pointer, `mem_req_o` rises in the next cycle. Word k of the descriptor is requested at byte address P + 4·k, where P is the pointer with its low 4 bits cleared. The address advances only on a cycle with `mem_req_o` and `mem_valid_i` both high, and it stays stable while `mem_valid_i` is low.
- R3: A sync whose fetch pointer is zero starts no memory request.
- R4: `node_o` never changes part-way through a fetch. When control word 0 has bit 31 clear, all sixteen words appear together in the cycle after the last word is accepted.
- R5: When control word 0 has bit 31 set, the fetched descriptor is held back. It appears on `node_o` in the cycle after the next sync.
- R6: When a fetch completes, `ptr_o` becomes word 9 of the descriptor with its low 4 bits cleared, unless a software pointer write is pending.
- R7: A write on `cpu_ptr_we_i` shows on `ptr_o`, with its low 4 bits cleared, from the next cycle onward. The next sync fetches from that value. A fetch that completes before that sync does not replace it.
- R8: A sync that arrives while a fetch is still running sets `late_o`, which then stays set until reset. `node_o` keeps its value, and fetching starts again at word 0 of the current fetch pointer.
- R9: `plane_on_o` is high only when a descriptor has been loaded and bits 1:0 of its properties word (word 13) are both zero.
- R10: Two descriptors whose word-9 links point at each other are loaded alternately, one per sync, with no software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | One-cycle field/frame sync pulse |
| cpu_ptr_we_i | input | 1 | Software write strobe for the fetch pointer |
| cpu_ptr_wdata_i | input | WORD_W | Value written to the fetch pointer |
| ptr_o | output | WORD_W | Read-back of the pointer the next sync will fetch from |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | WORD_W | Byte address of the requested word |
| mem_rdata_i | input | WORD_W | Read data, taken when `mem_valid_i` is high |
| mem_valid_i | input | 1 | Read data valid; completes the current request |
| node_o | output | 16·WORD_W | Loaded descriptor, word k at bits [32k+31:32k] |
| plane_on_o | output | 1 | Plane loaded and not hidden |
| late_o | output | 1 | Sticky flag: a fetch overran a sync |

## Verification
Internal faults reach the ports quickly. A wrong word index or base shows up on `mem_addr_o` in the first request cycle after a sync. A wrong link or pending-write choice shows on `ptr_o` in the cycle after the fetch completes, and a stale pending descriptor or an early commit shows on `node_o` one cycle after the deciding sync or last word. The bench compares every output against a behavioural model on every clock, so a fault of this kind surfaces within a single field period. That includes the alternating chain, the held-back descriptor, the zero-pointer stop and the overrun restart.

// File: rtl/nf_pkg.sv
package nf_pkg;
  // descriptor geometry; positions are decoded by hardware
  localparam int NODE_WORDS = 16;
  localparam int IDX_W      = $clog2(NODE_WORDS);
  localparam int W_CTRL     = 0;
  localparam int W_LINK     = 9;
  localparam int W_PROPS    = 13;
  localparam int DEFER_BIT  = 31;
  localparam int HIDE_W     = 2;
endpackage

// File: rtl/nf_ptr_reg.sv
module nf_ptr_reg
  import nf_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] link_i,
  input  logic              cpu_we_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic [WORD_W-1:0] ptr_o
);
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << ALIGN_BITS) - 1);

  function automatic logic [WORD_W-1:0] align_ptr(input logic [WORD_W-1:0] p);
    return p & ~LOW_MASK;
  endfunction

  logic [WORD_W-1:0] next_q, cpu_val_q;
  logic              cpu_pend_q;

  assign ptr_o = cpu_pend_q ? cpu_val_q : next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q     <= '0;
      cpu_val_q  <= '0;
      cpu_pend_q <= 1'b0;
    end else begin
      if (sync_i) begin
        next_q     <= ptr_o;
        cpu_pend_q <= 1'b0;
      end
      if (last_i) next_q <= align_ptr(link_i);
      if (cpu_we_i) begin
        cpu_pend_q <= 1'b1;
        cpu_val_q  <= align_ptr(cpu_wdata_i);
      end
    end
  end

  // R7: a software write is visible on the read-back next cycle
  a_r7_cpu_visible: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we_i |=> ptr_o == align_ptr($past(cpu_wdata_i)));

  // R6: completion adopts the descriptor link when no write is pending
  a_r6_link_adopted: assert property (@(posedge clk) disable iff (!rst_n)
    last_i && !cpu_we_i && !cpu_pend_q |=> ptr_o == align_ptr($past(link_i)));

  // R7: a pending write survives a completing fetch
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pend_q && !sync_i && !cpu_we_i |=> $stable(ptr_o));
endmodule

// File: rtl/nf_sequencer.sv
module nf_sequencer
  import nf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [WORD_W-1:0] fetch_addr_i,
  input  logic              mem_valid_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              take_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              late_o
);
  localparam int BYTES = WORD_W / 8;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

  function automatic logic [WORD_W-1:0] word_addr(input logic [WORD_W-1:0] base,
                                                  input logic [IDX_W-1:0]  k);
    return base + WORD_W'(k) * WORD_W'(BYTES);
  endfunction

  logic              busy_q, late_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] base_q;

  assign mem_req_o  = busy_q;
  assign mem_addr_o = word_addr(base_q, idx_q);
  assign take_o     = busy_q && mem_valid_i && !sync_i;
  assign last_o     = take_o && (idx_q == LAST_IDX);
  assign idx_o      = idx_q;
  assign late_o     = late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      late_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (sync_i) begin
      if (busy_q) late_q <= 1'b1;
      busy_q <= (fetch_addr_i != '0);
      idx_q  <= '0;
      base_q <= fetch_addr_i;
    end else if (take_o) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + IDX_W'(1);
    end
  end

  // R2: a stalled request keeps its address
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_valid_i && !sync_i |=> mem_req_o && $stable(mem_addr_o));

  // R2: every fetch starts at word 0 of the pointer
  a_r2_start_word0: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && fetch_addr_i != '0 |=> mem_req_o && mem_addr_o == $past(fetch_addr_i));

  // R3: a zero pointer starts nothing
  a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && fetch_addr_i == '0 |=> !mem_req_o);

  // R8: overrun raises the flag, and it sticks
  a_r8_late_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && mem_req_o |=> late_o);
  a_r8_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |=> late_o);
endmodule

// File: rtl/nf_shadow.sv
module nf_shadow
  import nf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_i,
  input  logic                         take_i,
  input  logic                         last_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [WORD_W-1:0]            rdata_i,
  output logic [WORD_W-1:0]            link_o,
  output logic [NODE_WORDS*WORD_W-1:0] node_o,
  output logic                         plane_on_o
);
  logic [WORD_W-1:0] stage_q [NODE_WORDS];
  logic [WORD_W-1:0] act_q   [NODE_WORDS];
  logic              pend_q, actv_q;
  logic              defer;

  assign defer  = stage_q[W_CTRL][DEFER_BIT];
  assign link_o = stage_q[W_LINK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NODE_WORDS; k++) begin
        stage_q[k] <= '0;
        act_q[k]   <= '0;
      end
      pend_q <= 1'b0;
      actv_q <= 1'b0;
    end else begin
      if (take_i) stage_q[idx_i] <= rdata_i;
      if (last_i) begin
        if (defer) begin
          pend_q <= 1'b1;
        end else begin
          for (int k = 0; k < NODE_WORDS; k++)
            act_q[k] <= (k == NODE_WORDS - 1) ? rdata_i : stage_q[k];
          actv_q <= 1'b1;
        end
      end
      if (sync_i && pend_q) begin
        for (int k = 0; k < NODE_WORDS; k++) act_q[k] <= stage_q[k];
        actv_q <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NODE_WORDS; g++) begin : g_out
    assign node_o[g*WORD_W +: WORD_W] = act_q[g];
  end

  assign plane_on_o = actv_q && (act_q[W_PROPS][HIDE_W-1:0] == '0);

  // R4: outputs move only on a completing word or a sync
  a_r4_atomic_update: assert property (@(posedge clk) disable iff (!rst_n)
    !last_i && !sync_i |=> $stable(node_o));

  // R5: a held-back descriptor waits for the sync
  a_r5_defer_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !sync_i |=> $stable(node_o) && pend_q);
endmodule

// File: rtl/node_chain_fetcher.sv
module node_chain_fetcher
  import nf_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sync_i,
  input  logic                         cpu_ptr_we_i,
  input  logic [WORD_W-1:0]            cpu_ptr_wdata_i,
  output logic [WORD_W-1:0]            ptr_o,
  output logic                         mem_req_o,
  output logic [WORD_W-1:0]            mem_addr_o,
  input  logic [WORD_W-1:0]            mem_rdata_i,
  input  logic                         mem_valid_i,
  output logic [NODE_WORDS*WORD_W-1:0] node_o,
  output logic                         plane_on_o,
  output logic                         late_o
);
  logic              take, last;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] link;

  nf_ptr_reg #(.WORD_W(WORD_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .last_i      (last),
    .link_i      (link),
    .cpu_we_i    (cpu_ptr_we_i),
    .cpu_wdata_i (cpu_ptr_wdata_i),
    .ptr_o       (ptr_o)
  );

  nf_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .fetch_addr_i (ptr_o),
    .mem_valid_i  (mem_valid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .take_o       (take),
    .last_o       (last),
    .idx_o        (idx),
    .late_o       (late_o)
  );

  nf_shadow #(.WORD_W(WORD_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .take_i     (take),
    .last_i     (last),
    .idx_i      (idx),
    .rdata_i    (mem_rdata_i),
    .link_o     (link),
    .node_o     (node_o),
    .plane_on_o (plane_on_o)
  );

  // R9: a hidden properties word never shows the plane
  a_r9_hidden_off: assert property (@(posedge clk) disable iff (!rst_n)
    node_o[W_PROPS*WORD_W +: HIDE_W] != '0 |-> !plane_on_o);
endmodule

// File: tb/node_chain_fetcher_test.sv
module node_chain_fetcher_test;
  localparam int W  = 32;
  localparam int NW = 16;

  logic clk = 1'b0, rst_n = 1'b0, sync_i = 1'b0, cpu_we = 1'b0, mem_valid = 1'b0;
  logic [W-1:0] cpu_wdata = '0, mem_rdata = '0;
  logic [W-1:0] ptr, mem_addr;
  logic         mem_req, plane_on, late;
  logic [NW*W-1:0] node;

  node_chain_fetcher uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .cpu_ptr_we_i(cpu_we), .cpu_ptr_wdata_i(cpu_wdata), .ptr_o(ptr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_valid_i(mem_valid), .node_o(node), .plane_on_o(plane_on), .late_o(late)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] mem [int];

  // behavioural reference state
  bit m_busy, m_cpend, m_pend, m_actv, m_late;
  int m_idx;
  logic [31:0] m_base, m_next, m_cval;
  logic [31:0] m_stage [NW];
  logic [31:0] m_act   [NW];

  function automatic logic [31:0] al(input logic [31:0] x);
    return {x[31:4], 4'h0};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  function automatic logic [NW*W-1:0] m_flat();
    logic [NW*W-1:0] f;
    for (int k = 0; k < NW; k++) f[k*32 +: 32] = m_act[k];
    return f;
  endfunction

  task automatic check(input string tag, input logic [NW*W-1:0] a, input logic [NW*W-1:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic put_node(input int base, input logic [31:0] ctrl, input logic [31:0] link,
                          input logic [31:0] props, input logic [31:0] seed);
    for (int k = 0; k < NW; k++) mem[base + 4*k] = seed + k;
    mem[base]      = ctrl;
    mem[base + 36] = link;
    mem[base + 52] = props;
  endtask

  task automatic model_step(input bit rst, input bit s, input bit we, input logic [31:0] wd,
                            input bit v, input logic [31:0] rdv);
    logic [31:0] fa;
    bit acc;
    if (rst) begin
      m_busy = 0; m_cpend = 0; m_pend = 0; m_actv = 0; m_late = 0; m_idx = 0;
      m_base = 0; m_next = 0; m_cval = 0;
      for (int k = 0; k < NW; k++) begin m_stage[k] = 0; m_act[k] = 0; end
      return;
    end
    fa  = m_cpend ? m_cval : m_next;
    acc = m_busy && v && !s;
    if (s) begin
      if (m_busy) m_late = 1;
      else if (m_pend) begin
        for (int k = 0; k < NW; k++) m_act[k] = m_stage[k];
        m_actv = 1; m_pend = 0;
      end
      m_next = fa; m_cpend = 0;
      m_busy = (fa != 0); m_idx = 0; m_base = fa;
    end
    if (acc) begin
      m_stage[m_idx] = rdv;
      if (m_idx == NW - 1) begin
        m_busy = 0;
        if (m_stage[0][31]) m_pend = 1;
        else begin
          for (int k = 0; k < NW; k++) m_act[k] = m_stage[k];
          m_actv = 1;
        end
        m_next = al(m_stage[9]);
      end else m_idx++;
    end
    if (we) begin m_cpend = 1; m_cval = al(wd); end
  endtask

  function automatic bit is_sync(input int c);
    return c == 8 || (c >= 20 && (c - 20) % 40 == 0);
  endfunction

  initial begin
    put_node(32'h100, 32'h0000_0005, 32'h140, 32'h0, 32'hA000_0000);
    put_node(32'h140, 32'h0000_0001, 32'h100, 32'h0, 32'hB000_0000);
    put_node(32'h200, 32'h8000_0002, 32'h247, 32'h1, 32'hC000_0000);
    put_node(32'h240, 32'h0000_0007, 32'h0,   32'h0, 32'hD000_0000);
    put_node(32'h300, 32'h0000_0004, 32'h300, 32'h0, 32'hE000_0000);
    model_step(1, 0, 0, 0, 0, 0);
    for (int cyc = 0; cyc < 520 && !finished; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        check("R2 mem_req_o", mem_req, m_busy);
        if (m_busy) check("R2 mem_addr_o", mem_addr, m_base + 4*m_idx);
        check("R6/R7 ptr_o", ptr, m_cpend ? m_cval : m_next);
        check("R4/R5 node_o", node, m_flat());
        check("R9 plane_on_o", plane_on, m_actv && m_act[13][1:0] == 2'b00);
        check("R8 late_o", late, m_late);
      end
      case (cyc)
        2: begin
          check("R1 ptr", ptr, 0); check("R1 node", node, 0); check("R1 plane", plane_on, 0);
          check("R1 late", late, 0); check("R1 req", mem_req, 0);
        end
        9:   check("R3 zero pointer no request", mem_req, 0);
        21: begin check("R2 first request", mem_req, 1); check("R2 base addr", mem_addr, 32'h100); end
        30:  check("R4 no partial update", node, 0);
        50: begin check("R10 first node A", node[9*32 +: 32], 32'h140); check("R9 plane on", plane_on, 1); end
        90:  check("R10 alternate to B", node[9*32 +: 32], 32'h100);
        130: check("R10 back to A", node[9*32 +: 32], 32'h140);
        151: check("R7 write visible aligned", ptr, 32'h200);
        170: check("R7 write beats completion", ptr, 32'h200);
        181: check("R2 aligned request", mem_addr, 32'h200);
        215: begin check("R5 held back", node[9*32 +: 32], 32'h100); check("R6 link adopted", ptr, 32'h240); end
        221: begin check("R5 applied after sync", node[0 +: 32], 32'h8000_0002); check("R9 hidden", plane_on, 0); end
        255: begin check("R6 zero link", ptr, 0); check("R4 node D", node[0 +: 32], 32'h7); end
        261: check("R3 chain end no request", mem_req, 0);
        341: begin
          check("R8 late set", late, 1); check("R8 node kept", node[0 +: 32], 32'h7);
          check("R8 restart word0", mem_addr, 32'h300);
        end
        450: begin check("R8 late sticky", late, 1); check("R10 self link node", node[9*32 +: 32], 32'h300); end
        default: ;
      endcase
      // drive inputs for the coming edge
      rst_n     = (cyc >= 3);
      sync_i    = is_sync(cyc);
      cpu_we    = (cyc == 10 || cyc == 150 || cyc == 270);
      cpu_wdata = (cyc == 10) ? 32'h100 : (cyc == 150) ? 32'h205 : 32'h300;
      if (cyc >= 300 && cyc < 400) mem_valid = mem_req && (cyc % 8 == 0);
      else                         mem_valid = mem_req && (cyc % 3 != 2);
      mem_rdata = rd(mem_addr);
      model_step(!rst_n, sync_i, cpu_we, cpu_wdata, mem_valid, mem_rdata);
    end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule